// File: doc/BRIEF.md
# Multi-Word AHB Transfer Sequencer

This block is the master side of an AHB-Lite port for multi-word loads and stores. A client hands it one request: a start address, a word count from 1 to 16, a direction, and all the store data packed into one wide vector. The sequencer then issues the words as an incrementing run of 32-bit transfers. The run starts with NONSEQ and continues with SEQ. It pipelines store data one cycle behind each address phase and returns load data on a simple valid/data output. HREADY wait states stall the whole machine.

AHB-Lite forbids a sequential run from stepping across a 1 KB address region. When the next word of a request would be the first word of a new region, the sequencer closes the current group and drives a single IDLE cycle. It then restarts at the region start with a fresh NONSEQ. After a load, the port normally shows two IDLE address cycles before the next request begins. A pending instruction-fetch request may use the second of those slots for its own single-word NONSEQ read. While the sequencer is idle, a fetch request also takes priority over a data request.

Top module: `mwx_sequencer`

## Requirements
- R1: Out of reset the port drives HTRANS IDLE (00), HSIZE word (010), done and rd_valid low, and req_ready high.
- R2: A request is taken only in a cycle where req_ready, req_valid and HREADY are all high. req_ready is high only while the sequencer is idle and no fetch is requested. A request with a count of 0 or more than 16 is ignored, and so is any request raised while the sequencer is busy. An ignored request causes no transfer on the bus.
- R3: The beats of a request go out at the word-aligned start address, and each later beat adds 4. The first beat of each group is NONSEQ (10) and the others are SEQ (11). HWRITE equals the request direction (1 = store).
- R4: A split happens when beats remain and the next beat's address has bits [9:2] equal to zero. Exactly one IDLE address cycle is then driven, followed by a NONSEQ at that address. A run whose last beat ends a region inserts no IDLE.
- R5: HTRANS is never BUSY (01). A SEQ beat directly follows a NONSEQ or SEQ address phase.
- R6: Store data for each beat appears on HWDATA during that beat's data phase, which is the cycle after its address phase completes. Data goes out in word order, with word k taken from bits [32k+31:32k] of req_wdata. The order is kept across a split.
- R7: For every load or fetch data phase that completes with HREADY high, rd_valid is high for one cycle and rd_data equals HRDATA. Loads return in beat order. rd_fetch is 1 only for fetch data.
- R8: While HREADY is low, HTRANS, HADDR, HWRITE and HWDATA hold their values, and no beat, data word or state change is taken.
- R9: done pulses high for exactly one cycle per accepted request, in the cycle where the last beat's data phase completes.
- R10: After the last beat of a load, one IDLE address cycle follows. In the second slot, a held fetch_req drives a NONSEQ read at fetch_addr with fetch_ack high. Without a fetch the second slot is IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 32 | Start byte address (low two bits ignored) |
| req_count | input | 5 | Number of words, 1 to 16 |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 512 | Store words, word k in bits [32k+31:32k] |
| fetch_req | input | 1 | Instruction fetch pending, held until fetch_ack |
| fetch_addr | input | 32 | Fetch word address |
| fetch_ack | output | 1 | Fetch address phase completes this cycle |
| htrans | output | 2 | AHB transfer type |
| haddr | output | 32 | AHB address |
| hwrite | output | 1 | AHB direction |
| hsize | output | 3 | AHB size, fixed to word |
| hwdata | output | 32 | AHB write data |
| hrdata | input | 32 | AHB read data |
| hready | input | 1 | AHB transfer done / wait state when low |
| rd_valid | output | 1 | Read word delivered |
| rd_data | output | 32 | Delivered read word |
| rd_fetch | output | 1 | Delivered word belongs to a fetch |
| done | output | 1 | Last data phase of a request completed |

## Verification
The assertions watch the bus on every cycle. They check that each SEQ address is the previous address plus 4 and never a region start, that SEQ only follows an active beat, that BUSY never appears, and that address and write data stay frozen through wait states. The exact placement of the single IDLE at a split, and the absence of one when a run ends on a region edge, are checked only by the bench. Its scenarios also cover the data-to-address pipeline, the IDLE-versus-fetch choice after a load, and the rejection of bad or early requests, because these depend on a whole request's history.

// File: rtl/mwx_pkg.sv
package mwx_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_GAP,
        ST_TAIL
    } seq_state_e;

    localparam logic [2:0] SIZE_WORD = 3'b010;

    // bookkeeping for the transfer that is in its data phase
    typedef struct packed {
        logic active;
        logic write;
        logic fetch;
        logic last;
    } dphase_t;

endpackage

// File: rtl/mwx_addr_step.sv
module mwx_addr_step #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 5,
    parameter int REGION_W = 10,
    parameter int STEP     = 4,
    localparam int STEP_LSB = $clog2(STEP)
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  beats_left,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              last_beat,
    output logic              split
);
    always_comb begin
        nxt_addr  = cur_addr + ADDR_W'(STEP);
        last_beat = (beats_left == CNT_W'(1));
        split     = !last_beat && (nxt_addr[REGION_W-1:STEP_LSB] == '0);
    end
endmodule

// File: rtl/mwx_wbuf.sv
module mwx_wbuf #(
    parameter int DATA_W    = 32,
    parameter int MAX_WORDS = 16,
    localparam int BUF_W    = DATA_W * MAX_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BUF_W-1:0]  load_data,
    input  logic              shift,
    output logic [DATA_W-1:0] hwdata
);
    logic [BUF_W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
            hwdata  <= '0;
        end else if (load) begin
            store_q <= load_data;
        end else if (shift) begin
            hwdata  <= store_q[DATA_W-1:0];
            store_q <= store_q >> DATA_W;
        end
    end
endmodule

// File: rtl/mwx_dphase.sv
module mwx_dphase
    import mwx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hready,
    input  logic              issue,
    input  logic              issue_write,
    input  logic              issue_fetch,
    input  logic              issue_last,
    input  logic [DATA_W-1:0] hrdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fetch,
    output logic              done
);
    dphase_t dp_q;
    logic    finish;

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= '0;
        end else if (hready) begin
            dp_q <= issue ? '{active: 1'b1, write: issue_write,
                              fetch: issue_fetch, last: issue_last} : '0;
        end
    end

    always_comb begin
        finish   = hready && dp_q.active;
        rd_valid = finish && !dp_q.write;
        rd_data  = hrdata;
        rd_fetch = dp_q.fetch;
        done     = finish && dp_q.last;
    end
endmodule

// File: rtl/mwx_sequencer.sv
module mwx_sequencer
    import mwx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_WORDS = 16,
    parameter int REGION_W  = 10,
    localparam int CNT_W    = $clog2(MAX_WORDS + 1),
    localparam int BUF_W    = DATA_W * MAX_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              req_write,
    input  logic [BUF_W-1:0]  req_wdata,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ack,
    output logic [1:0]        htrans,
    output logic [ADDR_W-1:0] haddr,
    output logic              hwrite,
    output logic [2:0]        hsize,
    output logic [DATA_W-1:0] hwdata,
    input  logic [DATA_W-1:0] hrdata,
    input  logic              hready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fetch,
    output logic              done
);
    localparam int STEP     = DATA_W / 8;
    localparam int STEP_LSB = $clog2(STEP);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(STEP - 1);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic              write_q;
    logic              first_q;

    logic [ADDR_W-1:0] nxt_addr;
    logic              last_beat;
    logic              split;
    logic              fetch_slot;
    logic              accept;
    logic              beat_go;
    logic              addr_go;

    mwx_addr_step #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REGION_W(REGION_W), .STEP(STEP)
    ) u_step (
        .cur_addr  (addr_q),
        .beats_left(remain_q),
        .nxt_addr  (nxt_addr),
        .last_beat (last_beat),
        .split     (split)
    );

    always_comb begin
        fetch_slot = (state_q == ST_IDLE) && fetch_req;
        req_ready  = (state_q == ST_IDLE) && !fetch_req;
        accept     = req_ready && req_valid && hready &&
                     (req_count != '0) && (req_count <= CNT_W'(MAX_WORDS));
        beat_go    = (state_q == ST_RUN) && hready;
        addr_go    = hready && ((state_q == ST_RUN) || fetch_slot);
        fetch_ack  = fetch_slot && hready;
        hsize      = SIZE_WORD;

        case (state_q)
            ST_RUN:  htrans = first_q ? TR_NONSEQ : TR_SEQ;
            ST_IDLE: htrans = fetch_req ? TR_NONSEQ : TR_IDLE;
            default: htrans = TR_IDLE;
        endcase
        haddr  = fetch_slot ? (fetch_addr & ALIGN_MASK) : addr_q;
        hwrite = (state_q == ST_RUN) && write_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            remain_q <= '0;
            write_q  <= 1'b0;
            first_q  <= 1'b0;
        end else if (hready) begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q  <= ST_RUN;
                        addr_q   <= req_addr & ALIGN_MASK;
                        remain_q <= req_count;
                        write_q  <= req_write;
                        first_q  <= 1'b1;
                    end
                end
                ST_RUN: begin
                    addr_q   <= nxt_addr;
                    remain_q <= remain_q - CNT_W'(1);
                    if (last_beat) begin
                        state_q <= write_q ? ST_IDLE : ST_TAIL;
                    end else if (split) begin
                        state_q <= ST_GAP;
                        first_q <= 1'b1;
                    end else begin
                        first_q <= 1'b0;
                    end
                end
                ST_GAP:  state_q <= ST_RUN;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    mwx_wbuf #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)) u_wbuf (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_data(req_wdata),
        .shift    (beat_go && write_q),
        .hwdata   (hwdata)
    );

    mwx_dphase #(.DATA_W(DATA_W)) u_dphase (
        .clk        (clk),
        .rst        (rst),
        .hready     (hready),
        .issue      (addr_go),
        .issue_write(hwrite),
        .issue_fetch(fetch_slot),
        .issue_last ((state_q == ST_RUN) && last_beat),
        .hrdata     (hrdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_fetch   (rd_fetch),
        .done       (done)
    );
endmodule

// File: rtl/mwx_sequencer_chk.sv
module mwx_sequencer_chk #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int REGION_W = 10,
    localparam int STEP_LSB = $clog2(DATA_W / 8)
) (
    input logic              clk,
    input logic              rst,
    input logic              hready,
    input logic [1:0]        htrans,
    input logic [ADDR_W-1:0] haddr,
    input logic              hwrite,
    input logic [DATA_W-1:0] hwdata
);
    // R3
    seq_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b11 && $past(hready)) |-> haddr == $past(haddr) + ADDR_W'(DATA_W / 8));

    // R4
    seq_no_region_start_chk: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b11) |-> haddr[REGION_W-1:STEP_LSB] != '0);

    // R5
    seq_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b11 && $past(hready)) |-> $past(htrans[1]));

    // R5
    no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        htrans != 2'b01);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(hready) && $past(htrans) != 2'b00) |->
            ($stable(htrans) && $stable(haddr) && $stable(hwrite)));

    // R8
    wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(hready) |-> $stable(hwdata));
endmodule

bind mwx_sequencer mwx_sequencer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_W(REGION_W)
) u_chk (.*);

// File: tb/mwx_sequencer_test.sv
module mwx_sequencer_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [4:0]   req_count = '0;
    logic         req_write = 1'b0;
    logic [511:0] req_wdata = '0;
    logic         fetch_req = 1'b0;
    logic [31:0]  fetch_addr = '0;
    logic         fetch_ack;
    logic [1:0]   htrans;
    logic [31:0]  haddr;
    logic         hwrite;
    logic [2:0]   hsize;
    logic [31:0]  hwdata;
    logic [31:0]  hrdata;
    logic         hready = 1'b1;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic         rd_fetch;
    logic         done;

    always #5 clk = ~clk;

    mwx_sequencer uut (.*);

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int salt = 1;

    // ---------------- slave model ----------------
    logic [31:0] mem [0:1023];
    logic        s_act, s_wr;
    logic [9:0]  s_idx;
    logic [7:0]  lfsr;
    bit          wait_mode = 0;

    function automatic logic [31:0] init_word(int i);
        return 32'hA5000000 | i;
    endfunction

    function automatic logic [31:0] pat(logic [31:0] a, int s);
        return (a * 32'h9E37) ^ (s << 20) ^ 32'hC0DE0000;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) mem[i] <= init_word(i);
            s_act  <= 1'b0;
            s_wr   <= 1'b0;
            s_idx  <= '0;
            lfsr   <= 8'h5B;
            hready <= 1'b1;
        end else begin
            if (hready) begin
                if (s_act && s_wr) mem[s_idx] <= hwdata;
                s_act <= htrans[1];
                s_wr  <= hwrite;
                s_idx <= haddr[11:2];
            end
            lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            hready <= wait_mode ? (lfsr[1:0] != 2'b00) : 1'b1;
        end
    end
    assign hrdata = mem[s_idx];

    // ---------------- monitors ----------------
    logic [1:0]  tr_t [0:63];
    logic [31:0] tr_a [0:63];
    logic        tr_w [0:63];
    int          tr_n = 0;
    bit          rec = 0;
    bit          started = 0;
    logic [31:0] rd_d [0:63];
    logic        rd_f [0:63];
    int          rd_n = 0;
    int          dn = 0;

    always @(posedge clk) begin
        if (!rst && rec) begin
            if (hready && (started || htrans != 2'b00)) begin
                started = 1;
                if (tr_n < 64) begin
                    tr_t[tr_n] = htrans;
                    tr_a[tr_n] = haddr;
                    tr_w[tr_n] = hwrite;
                end
                tr_n++;
            end
            if (rd_valid) begin
                if (rd_n < 64) begin
                    rd_d[rd_n] = rd_data;
                    rd_f[rd_n] = rd_fetch;
                end
                rd_n++;
            end
            if (done) dn++;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run hung (actual cycles %0d, expected < 150000)", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // ---------------- generic transfer driver/checker ----------------
    task automatic do_xfer(logic [31:0] a, int cnt, bit wr, bit fet,
                           logic [31:0] fa, bit stray, string scen);
        logic [1:0]  ex_t [0:63];
        logic [31:0] ex_a [0:63];
        logic        ex_w [0:63];
        string       ex_r [0:63];
        int          en = 0;
        int          t;
        int          extra = 0;
        int          exp_rd;
        logic [31:0] ea;

        for (int i = 0; i < cnt; i++) begin
            ea = a + 32'(4 * i);
            if (i != 0 && ea[9:2] == 8'd0) begin
                ex_t[en] = 2'b00; ex_a[en] = ea; ex_w[en] = 0; ex_r[en] = "R4"; en++;
            end
            ex_t[en] = (i == 0 || ea[9:2] == 8'd0) ? 2'b10 : 2'b11;
            ex_a[en] = ea; ex_w[en] = wr;
            ex_r[en] = (i != 0 && ea[9:2] == 8'd0) ? "R4" : "R3";
            en++;
        end
        ex_t[en] = 2'b00; ex_a[en] = 0; ex_w[en] = 0; ex_r[en] = "R10"; en++;
        if (!wr) begin
            ex_t[en] = fet ? 2'b10 : 2'b00; ex_a[en] = fa; ex_w[en] = 0;
            ex_r[en] = "R10"; en++;
        end

        for (int k = 0; k < 16; k++) req_wdata[32*k +: 32] = pat(a + 32'(4 * k), salt);
        tr_n = 0; started = 0; rd_n = 0; dn = 0; rec = 1;

        @(negedge clk);
        req_addr = a; req_count = 5'(cnt); req_write = wr; req_valid = 1;
        t = 0;
        while (!(req_ready && hready) && t < 1000) begin @(negedge clk); t++; end
        @(negedge clk);
        req_valid = 0;
        if (stray) begin
            req_addr = 32'h900; req_count = 5'd2; req_valid = 1;
            repeat (3) @(negedge clk);
            req_valid = 0;
        end
        if (fet) begin
            fetch_req = 1; fetch_addr = fa;
            t = 0;
            while (!fetch_ack && t < 1000) begin @(negedge clk); t++; end
            @(negedge clk);
            fetch_req = 0;
        end
        t = 0;
        while (dn == 0 && t < 2000) begin @(negedge clk); t++; end
        repeat (6) @(negedge clk);
        rec = 0;

        chk(dn == 1, "R9", {scen, " done pulses"}, dn, 1);
        chk(tr_n >= en, "R3", {scen, " address phases recorded"}, tr_n, en);
        for (int i = 0; i < en && i < tr_n; i++) begin
            chk(tr_t[i] == ex_t[i], ex_r[i], $sformatf("%s htrans[%0d]", scen, i), tr_t[i], ex_t[i]);
            if (ex_t[i] != 2'b00) begin
                chk(tr_a[i] == ex_a[i], ex_r[i], $sformatf("%s haddr[%0d]", scen, i), tr_a[i], ex_a[i]);
                chk(tr_w[i] == ex_w[i], ex_r[i], $sformatf("%s hwrite[%0d]", scen, i), tr_w[i], ex_w[i]);
            end
        end
        for (int i = en; i < tr_n && i < 64; i++) if (tr_t[i] != 2'b00) extra++;
        chk(extra == 0, "R2", {scen, " no extra transfers"}, extra, 0);

        if (wr) begin
            for (int k = 0; k < cnt; k++) begin
                ea = a + 32'(4 * k);
                chk(mem[ea[11:2]] == pat(ea, salt), "R6",
                    $sformatf("%s stored word %0d", scen, k), mem[ea[11:2]], pat(ea, salt));
            end
        end else begin
            exp_rd = cnt + (fet ? 1 : 0);
            chk(rd_n == exp_rd, "R7", {scen, " read words"}, rd_n, exp_rd);
            for (int k = 0; k < cnt && k < rd_n; k++) begin
                ea = a + 32'(4 * k);
                chk(rd_d[k] == mem[ea[11:2]] && rd_f[k] == 0, "R7",
                    $sformatf("%s read word %0d", scen, k), rd_d[k], mem[ea[11:2]]);
            end
            if (fet && rd_n > cnt)
                chk(rd_d[cnt] == mem[fa[11:2]] && rd_f[cnt] == 1, "R10",
                    {scen, " fetch word"}, rd_d[cnt], mem[fa[11:2]]);
        end
        salt++;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(htrans == 2'b00, "R1", "reset htrans", htrans, 0);
        chk(hsize == 3'b010, "R1", "reset hsize", hsize, 3'b010);
        chk(done == 0 && rd_valid == 0, "R1", "reset done/rd_valid", {done, rd_valid}, 0);
        chk(req_ready == 1, "R1", "reset req_ready", req_ready, 1);
    endtask

    task automatic t_store_split();
        do_xfer(32'h3F8, 4, 1, 0, 0, 0, "store split R4 R6");
    endtask

    task automatic t_load_plain();
        do_xfer(32'h100, 4, 0, 0, 0, 0, "load plain R7 R10");
    endtask

    task automatic t_load_fetch();
        do_xfer(32'h200, 2, 0, 1, 32'h840, 0, "load then fetch R10");
    endtask

    task automatic t_wait_states();
        wait_mode = 1;
        do_xfer(32'h7F0, 8, 1, 0, 0, 0, "wait store R8");
        do_xfer(32'h7F0, 8, 0, 0, 0, 0, "wait load R8");
        do_xfer(32'hBF8, 3, 0, 1, 32'h10, 0, "wait fetch R8");
        wait_mode = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_region_end();
        do_xfer(32'h3C0, 16, 0, 0, 0, 0, "sixteen ending at region edge R4");
        do_xfer(32'hC04, 16, 1, 0, 0, 0, "sixteen store R3");
    endtask

    task automatic t_single();
        do_xfer(32'h47C, 1, 1, 0, 0, 0, "single store R3");
        do_xfer(32'h3FC, 1, 0, 0, 0, 0, "single load R3");
    endtask

    task automatic t_bad_count();
        tr_n = 0; started = 0; dn = 0; rec = 1;
        @(negedge clk);
        req_addr = 32'h500; req_write = 1; req_count = 5'd0; req_valid = 1;
        repeat (4) @(negedge clk);
        req_count = 5'd17;
        repeat (4) @(negedge clk);
        req_valid = 0;
        repeat (4) @(negedge clk);
        rec = 0;
        chk(tr_n == 0, "R2", "count 0/17 bus activity", tr_n, 0);
        chk(dn == 0, "R2", "count 0/17 done", dn, 0);
    endtask

    task automatic t_busy_ignore();
        do_xfer(32'h600, 6, 1, 0, 0, 1, "request while busy R2");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_store_split();
        t_load_plain();
        t_load_fetch();
        t_wait_states();
        t_region_end();
        t_single();
        t_bad_count();
        t_busy_ignore();
        summary();
        $finish;
    end
endmodule